// File: doc/BRIEF.md
# Debug Hart Selection and Halt-on-Reset Controller

This block sits inside a debug module and turns writes to one 32-bit control word into per-hart requests for up to `NUM_HARTS` harts. Each write names one hart through a 20-bit index that is split over two 10-bit fields of the word. The same write can ask that hart to halt or resume, acknowledge its have-reset flag, and set or clear its sticky halt-on-reset request. All of these act on the index carried in that write.

Every hart has a sticky have-reset flag, which is set while the hart's reset input is high. It has a level halt request and a one-cycle resume pulse. When a hart leaves reset with its halt-on-reset request set, the block raises that hart's halt request without any write. The halt-on-reset request stays set until it is cleared explicitly. The block also drives a system reset output and a module-active bit. While the module is inactive, every other piece of state is held at zero, which gives software a way back to a known state.

Top module: `dbg_hartctl`

## Requirements
- R1: After `rst_n` is low, every output is 0 except `rst_halt_supp_o`, which equals the `RST_HALT_EN` parameter.
- R2: `ctl_rdata_o` reads bit 0 = module active, bit 1 = system reset, bits 25:16 = low 10 bits of the selected index, bits 15:6 = high 10 bits. All other bits read 0, including bit 26, the multi-hart select bit.
- R3: Every write loads `dm_active_o` from bit 0 of the data. A write that occurs while `dm_active_o` is 0, or that carries bit 0 = 0, changes nothing else.
- R4: While the module is inactive, the index, the system reset and all per-hart state are held at 0.
- R5: The selected index is {bits 15:6, bits 25:16}, and a write's per-hart actions apply to the index in that same write. An index of `NUM_HARTS` or more changes no hart.
- R6: Bit 31 of a write is loaded into the selected hart's `halt_req_o` level.
- R7: Bit 30 with bit 31 = 0 gives a one-cycle pulse on the selected hart's `resume_req_o`. With bit 31 = 1, no pulse occurs.
- R8: `have_reset_o[h]` is set in every cycle that `hart_rst_i[h]` is high. It clears only on a write with bit 28 = 1 that selects h, in a cycle when its reset is low.
- R9: Bit 3 sets and bit 2 clears the selected hart's halt-on-reset request. When both are 1, set wins. The request persists across any number of resets.
- R10: A falling edge on `hart_rst_i[h]` while h's halt-on-reset request is set raises `halt_req_o[h]` on the next edge. This overrides a same-cycle write to h and suppresses a resume pulse from that write.
- R11: `sys_rst_o` is loaded from bit 1 of each accepted write.
- R12: `sel_have_reset_o` and `sel_rst_halt_o` show the state of the currently selected hart. Both read 0 for an index of `NUM_HARTS` or more.
- R13: With `RST_HALT_EN` = 0, bits 3 and 2 are ignored, no automatic halt occurs, and `rst_halt_supp_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en_i | input | 1 | Write strobe for the control word |
| ctl_wdata_i | input | 32 | Control word data |
| hart_rst_i | input | NUM_HARTS | Per-hart reset, high while the hart is in reset |
| ctl_rdata_o | output | 32 | Control word read-back |
| halt_req_o | output | NUM_HARTS | Per-hart halt request level |
| resume_req_o | output | NUM_HARTS | Per-hart one-cycle resume pulse |
| have_reset_o | output | NUM_HARTS | Per-hart sticky have-reset flag |
| sel_have_reset_o | output | 1 | Have-reset flag of the selected hart |
| sel_rst_halt_o | output | 1 | Halt-on-reset request of the selected hart |
| sys_rst_o | output | 1 | System reset request |
| dm_active_o | output | 1 | Module-active bit |
| rst_halt_supp_o | output | 1 | Halt-on-reset support indicator |

## Verification
Two functions can land on the same hart in the same cycle: a debugger write to a hart, and that hart's exit from reset with halt-on-reset armed. The bench holds a hart in reset and releases it in exactly the cycle that it writes halt = 0 with resume = 1 to that hart. It then expects the halt request high and no resume pulse. It also releases a reset while an acknowledge targets the same hart, and issues set and clear of halt-on-reset in one write. A bench-side model of the requirements predicts every output after every cycle.

// File: rtl/hsc_pkg.sv
// Package: field positions of the control word and the decoded command type.
// Assumes a 32-bit control word with a 20-bit hart index in two halves.
package hsc_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = 10;
    localparam int IDX_W      = 2 * HALF_W;
    localparam int B_HALT     = 31;
    localparam int B_RESUME   = 30;
    localparam int B_ACK      = 28;
    localparam int LO_LSB     = 16;
    localparam int HI_LSB     = 6;
    localparam int B_RH_SET   = 3;
    localparam int B_RH_CLR   = 2;
    localparam int B_SYSRST   = 1;
    localparam int B_ACTIVE   = 0;

    typedef struct packed {
        logic             halt;
        logic             resume;
        logic             ack;
        logic             rh_set;
        logic             rh_clr;
        logic             sysrst;
        logic             active;
        logic [IDX_W-1:0] idx;
    } ctl_cmd_t;

    // Split a written control word into its command fields.
    function automatic ctl_cmd_t decode_ctl(input logic [WORD_W-1:0] w);
        ctl_cmd_t d;
        d.halt   = w[B_HALT];
        d.resume = w[B_RESUME];
        d.ack    = w[B_ACK];
        d.rh_set = w[B_RH_SET];
        d.rh_clr = w[B_RH_CLR];
        d.sysrst = w[B_SYSRST];
        d.active = w[B_ACTIVE];
        d.idx    = {w[HI_LSB +: HALF_W], w[LO_LSB +: HALF_W]};
        return d;
    endfunction
endpackage

// File: rtl/hsc_ctl_reg.sv
// Control word register: keeps the active bit, the system reset and the
// selected index. It decides whether a write is accepted.
// Assumes: a write is accepted only when the module is already active and
// the written active bit is 1. All other state is cleared while inactive.
module hsc_ctl_reg
    import hsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output ctl_cmd_t            cmd_o,
    output logic                apply_o,
    output logic                active_o,
    output logic                sysrst_o,
    output logic [IDX_W-1:0]    idx_o
);
    logic             active_q;
    logic             sysrst_q;
    logic [IDX_W-1:0] idx_q;

    assign cmd_o   = decode_ctl(wdata_i);
    assign apply_o = wr_en_i && active_q && cmd_o.active;

    // Module-active bit: loaded by every write.
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= 1'b0;
        else if (wr_en_i) active_q <= cmd_o.active;
    end

    // Index and system reset: held at zero while inactive, loaded on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_q) begin
            sysrst_q <= 1'b0;
            idx_q    <= '0;
        end else if (apply_o) begin
            sysrst_q <= cmd_o.sysrst;
            idx_q    <= cmd_o.idx;
        end
    end

    assign active_o = active_q;
    assign sysrst_o = sysrst_q;
    assign idx_o    = idx_q;

    p_active_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (active_q == $past(wdata_i[B_ACTIVE])));
    p_sysrst_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> (sysrst_q == $past(wdata_i[B_SYSRST])));
    p_idle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |=> (!sysrst_q && idx_q == '0));
endmodule

// File: rtl/hsc_hart_slice.sv
// Per-hart state: halt level, resume pulse, sticky have-reset flag and the
// optional sticky halt-on-reset request with its automatic halt on reset exit.
// Assumes hit_i is already qualified by an accepted write that names this hart.
module hsc_hart_slice #(
    parameter bit RST_HALT_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic hit_i,
    input  logic halt_bit_i,
    input  logic resume_bit_i,
    input  logic ack_bit_i,
    input  logic set_rh_i,
    input  logic clr_rh_i,
    input  logic hart_rst_i,
    output logic halt_o,
    output logic resume_o,
    output logic have_reset_o,
    output logic rst_halt_o
);
    logic rst_seen_q;
    logic halt_q;
    logic resume_q;
    logic have_q;
    logic rh_q;
    logic auto_halt;

    // Previous value of the hart reset, used to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_seen_q <= 1'b0;
        else        rst_seen_q <= hart_rst_i;
    end

    assign auto_halt = rst_seen_q && !hart_rst_i && rh_q;

    // Halt level: the automatic halt takes priority over the written value.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) halt_q <= 1'b0;
        else if (auto_halt)      halt_q <= 1'b1;
        else if (hit_i)          halt_q <= halt_bit_i;
    end

    // Resume pulse: one cycle, dropped when halting in the same write or on auto halt.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) resume_q <= 1'b0;
        else resume_q <= hit_i && resume_bit_i && !halt_bit_i && !auto_halt;
    end

    // Sticky have-reset flag: reset input wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i)    have_q <= 1'b0;
        else if (hart_rst_i)        have_q <= 1'b1;
        else if (hit_i && ack_bit_i) have_q <= 1'b0;
    end

    generate
        if (RST_HALT_EN) begin : g_rh
            // Halt-on-reset request: set wins over clear, never self-clears.
            always_ff @(posedge clk) begin
                if (!rst_n || !active_i)   rh_q <= 1'b0;
                else if (hit_i && set_rh_i) rh_q <= 1'b1;
                else if (hit_i && clr_rh_i) rh_q <= 1'b0;
            end
        end else begin : g_no_rh
            assign rh_q = 1'b0;
        end
    endgenerate

    assign halt_o       = halt_q;
    assign resume_o     = resume_q;
    assign have_reset_o = have_q;
    assign rst_halt_o   = rh_q;

    p_auto_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && rh_q && $fell(hart_rst_i)) |=> halt_q);
    p_have_reset_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && hart_rst_i) |=> have_q);
    p_inactive_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!halt_q && !resume_q && !have_q && !rh_q));
    p_resume_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |-> !halt_q);
endmodule

// File: rtl/hsc_sel_status.sv
// Selected-hart status: picks the flags of the hart named by the current
// index. Returns 0 when the index names no existing hart.
module hsc_sel_status
    import hsc_pkg::*;
#(
    parameter int NUM_HARTS = 4
) (
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [NUM_HARTS-1:0] have_vec_i,
    input  logic [NUM_HARTS-1:0] rh_vec_i,
    output logic                 sel_have_o,
    output logic                 sel_rh_o
);
    // Compare-and-OR selection: no match for indexes at or above NUM_HARTS.
    always_comb begin
        sel_have_o = 1'b0;
        sel_rh_o   = 1'b0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (idx_i == IDX_W'(h)) begin
                sel_have_o = sel_have_o | have_vec_i[h];
                sel_rh_o   = sel_rh_o   | rh_vec_i[h];
            end
        end
    end
endmodule

// File: rtl/dbg_hartctl.sv
// Debug hart selection and halt-on-reset controller top. It decodes the
// control word, fans the accepted command out to one slice per hart and
// reports the selected hart's status.
// Assumes NUM_HARTS <= 2**20 and only one hart selected per write.
module dbg_hartctl
    import hsc_pkg::*;
#(
    parameter int NUM_HARTS   = 4,
    parameter bit RST_HALT_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr_en_i,
    input  logic [31:0]          ctl_wdata_i,
    input  logic [NUM_HARTS-1:0] hart_rst_i,
    output logic [31:0]          ctl_rdata_o,
    output logic [NUM_HARTS-1:0] halt_req_o,
    output logic [NUM_HARTS-1:0] resume_req_o,
    output logic [NUM_HARTS-1:0] have_reset_o,
    output logic                 sel_have_reset_o,
    output logic                 sel_rst_halt_o,
    output logic                 sys_rst_o,
    output logic                 dm_active_o,
    output logic                 rst_halt_supp_o
);
    localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_HARTS);

    ctl_cmd_t               cmd;
    logic                   apply;
    logic                   active;
    logic                   sysrst;
    logic [IDX_W-1:0]       idx_q;
    logic [NUM_HARTS-1:0]   rh_vec;

    hsc_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (ctl_wr_en_i),
        .wdata_i  (ctl_wdata_i),
        .cmd_o    (cmd),
        .apply_o  (apply),
        .active_o (active),
        .sysrst_o (sysrst),
        .idx_o    (idx_q)
    );

    generate
        for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
            logic hit;
            assign hit = apply && (cmd.idx == IDX_W'(h));
            hsc_hart_slice #(.RST_HALT_EN(RST_HALT_EN)) u_slice (
                .clk          (clk),
                .rst_n        (rst_n),
                .active_i     (active),
                .hit_i        (hit),
                .halt_bit_i   (cmd.halt),
                .resume_bit_i (cmd.resume),
                .ack_bit_i    (cmd.ack),
                .set_rh_i     (cmd.rh_set),
                .clr_rh_i     (cmd.rh_clr),
                .hart_rst_i   (hart_rst_i[h]),
                .halt_o       (halt_req_o[h]),
                .resume_o     (resume_req_o[h]),
                .have_reset_o (have_reset_o[h]),
                .rst_halt_o   (rh_vec[h])
            );
        end
    endgenerate

    hsc_sel_status #(.NUM_HARTS(NUM_HARTS)) u_sel (
        .idx_i      (idx_q),
        .have_vec_i (have_reset_o),
        .rh_vec_i   (rh_vec),
        .sel_have_o (sel_have_reset_o),
        .sel_rh_o   (sel_rst_halt_o)
    );

    // Read-back: multi-hart select (bit 26) and pulse-only fields read 0.
    assign ctl_rdata_o = {5'b0, 1'b0, idx_q[HALF_W-1:0], idx_q[IDX_W-1:HALF_W],
                          4'b0, sysrst, active};
    assign sys_rst_o       = sysrst;
    assign dm_active_o     = active;
    assign rst_halt_supp_o = RST_HALT_EN;

    p_oor_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && cmd.idx >= IDX_LIMIT) |=> $stable(rh_vec));
    p_sel_oor_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q >= IDX_LIMIT) |-> (!sel_have_reset_o && !sel_rst_halt_o));
endmodule

// File: tb/dbg_hartctl_tb_top.sv
module dbg_hartctl_tb_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wdata;
    logic [N-1:0] hart_rst;

    logic [31:0]  rdata, rdata_nr;
    logic [N-1:0] halt_req, resume_req, have_rst;
    logic [N-1:0] halt_nr, resume_nr, have_nr;
    logic sel_have, sel_rh, sys_rst, active, supp;
    logic sel_have_nr, sel_rh_nr, sys_nr, active_nr, supp_nr;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic         m_act, m_sys;
    logic [19:0]  m_sel;
    logic [N-1:0] m_halt, m_res, m_have, m_rh, m_rprev;

    always #5 clk = ~clk;

    dbg_hartctl #(.NUM_HARTS(N), .RST_HALT_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en_i(wr_en), .ctl_wdata_i(wdata),
        .hart_rst_i(hart_rst), .ctl_rdata_o(rdata), .halt_req_o(halt_req),
        .resume_req_o(resume_req), .have_reset_o(have_rst),
        .sel_have_reset_o(sel_have), .sel_rst_halt_o(sel_rh),
        .sys_rst_o(sys_rst), .dm_active_o(active), .rst_halt_supp_o(supp));

    dbg_hartctl #(.NUM_HARTS(N), .RST_HALT_EN(1'b0)) dut_nr (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en_i(wr_en), .ctl_wdata_i(wdata),
        .hart_rst_i(hart_rst), .ctl_rdata_o(rdata_nr), .halt_req_o(halt_nr),
        .resume_req_o(resume_nr), .have_reset_o(have_nr),
        .sel_have_reset_o(sel_have_nr), .sel_rst_halt_o(sel_rh_nr),
        .sys_rst_o(sys_nr), .dm_active_o(active_nr), .rst_halt_supp_o(supp_nr));

    function automatic logic [31:0] mk(input logic h, input logic r, input logic a,
                                       input logic s, input logic c, input logic [19:0] idx,
                                       input logic sy, input logic ac);
        logic [31:0] w;
        w = '0;
        w[31] = h; w[30] = r; w[28] = a; w[3] = s; w[2] = c;
        w[25:16] = idx[9:0]; w[15:6] = idx[19:10];
        w[1] = sy; w[0] = ac;
        return w;
    endfunction

    task automatic chk(input string req, input string ctx, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s (%s): got %h expected %h", req, ctx, got, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] exp_rd;
        exp_rd = {6'b0, m_sel[9:0], m_sel[19:10], 4'b0, m_sys, m_act};
        chk("R6",  ctx, 32'(halt_req), 32'(m_halt));
        chk("R7",  ctx, 32'(resume_req), 32'(m_res));
        chk("R8",  ctx, 32'(have_rst), 32'(m_have));
        chk("R11", ctx, 32'(sys_rst), 32'(m_sys));
        chk("R3",  ctx, 32'(active), 32'(m_act));
        chk("R2",  ctx, rdata, exp_rd);
        chk("R12", ctx, 32'(sel_rh),   (m_sel < 20'(N)) ? 32'(m_rh[m_sel[1:0]])   : 32'd0);
        chk("R12", ctx, 32'(sel_have), (m_sel < 20'(N)) ? 32'(m_have[m_sel[1:0]]) : 32'd0);
    endtask

    // One clock: drive inputs, advance the model across the edge, then check.
    task automatic cycle(input logic en, input logic [31:0] w, input string ctx);
        logic [N-1:0] auto_h;
        logic [19:0]  idx;
        wr_en = en;
        wdata = w;
        @(posedge clk);
        m_res = '0;
        if (!m_act) begin
            m_halt = '0; m_have = '0; m_rh = '0; m_sys = 1'b0; m_sel = '0;
        end else begin
            auto_h = m_rprev & ~hart_rst & m_rh;
            if (en && w[0]) begin
                idx = {w[15:6], w[25:16]};
                m_sel = idx;
                m_sys = w[1];
                if (idx < 20'(N)) begin
                    m_halt[idx[1:0]] = w[31];
                    if (w[30] && !w[31]) m_res[idx[1:0]] = 1'b1;
                    if (w[28]) m_have[idx[1:0]] = 1'b0;
                    if (w[3]) m_rh[idx[1:0]] = 1'b1;
                    else if (w[2]) m_rh[idx[1:0]] = 1'b0;
                end
            end
            m_have = m_have | hart_rst;
            m_halt = m_halt | auto_h;
            m_res  = m_res & ~auto_h;
        end
        if (en) m_act = w[0];
        m_rprev = hart_rst;
        @(negedge clk);
        wr_en = 1'b0;
        check_all(ctx);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wdata = '0; hart_rst = '0;
        m_act = 0; m_sys = 0; m_sel = '0; m_halt = '0; m_res = '0;
        m_have = '0; m_rh = '0; m_rprev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1 reset");
        chk("R1",  "support flag", 32'(supp), 32'd1);
        chk("R13", "support flag off", 32'(supp_nr), 32'd0);

        // R3: activate the module
        cycle(1, mk(0,0,0,0,0,20'd0,0,1), "R3 activate");

        // R2/R5: junk bits and bit 26 read back as 0; out-of-range index
        cycle(1, mk(1,0,1,1,0,20'h4C6A5,1,1) | 32'h2C00_0030, "R2 readback R5 oor");

        // R6/R5: sweep halt over every index, then out-of-range ones
        for (int h = 0; h < N; h++) cycle(1, mk(1,0,0,0,0,20'(h),0,1), "R6 halt sweep");
        for (int h = N; h < 8; h++) cycle(1, mk(0,0,0,1,0,20'(h),0,1), "R5 oor no effect");
        cycle(1, mk(0,0,0,1,0,20'h00401,0,1), "R5 high half nonzero");

        // R7: resume pulse, and halt+resume gives no pulse
        cycle(1, mk(0,1,0,0,0,20'd1,0,1), "R7 resume");
        cycle(1, mk(1,1,0,0,0,20'd2,0,1), "R7 halt blocks resume");
        cycle(0, '0, "R7 pulse ends");

        // R8: have-reset set while reset held; ack during reset does not clear
        hart_rst = 4'b1011;
        cycle(0, '0, "R8 set");
        cycle(1, mk(0,0,1,0,0,20'd0,0,1), "R8 ack during reset");
        hart_rst = 4'b0000;
        cycle(1, mk(0,0,1,0,0,20'd0,0,1), "R8 ack at release");
        cycle(1, mk(0,0,1,0,0,20'd3,0,1), "R8 ack hart3");
        cycle(1, mk(0,0,1,0,0,20'd5,0,1), "R8 R5 ack oor");

        // R9: set/clear halt-on-reset on each hart
        for (int h = 0; h < N; h++) cycle(1, mk(0,0,0,1,0,20'(h),0,1), "R9 set sweep");
        cycle(1, mk(0,0,0,0,1,20'd0,0,1), "R9 clear");
        cycle(1, mk(0,0,0,1,1,20'd3,0,1), "R9 set wins");
        cycle(1, mk(0,0,0,0,1,20'd3,0,1), "R9 clear 3");
        chk("R13", "no-support sel", 32'(sel_rh_nr), 32'd0);

        // Clear all halts before the reset-exit tests
        for (int h = 0; h < N; h++) cycle(1, mk(0,0,0,0,0,20'(h),0,1), "R6 clear");

        // R10: harts 1,2 armed, 3 not armed; pulse resets
        hart_rst = 4'b1110;
        cycle(0, '0, "R10 in reset");
        hart_rst = 4'b0000;
        cycle(0, '0, "R10 auto halt");
        chk("R13", "no auto halt", 32'(halt_nr), 32'd0);
        // R9: the request persists, so a second reset halts again
        cycle(1, mk(0,0,0,0,0,20'd2,0,1), "R6 clear 2");
        hart_rst = 4'b0100;
        cycle(0, '0, "R9 second reset");
        hart_rst = 4'b0000;
        cycle(0, '0, "R9 R10 halts again");
        // R10: reset exit in the same cycle as a resume write to that hart
        cycle(1, mk(0,0,0,0,0,20'd1,0,1), "R6 clear 1");
        hart_rst = 4'b0010;
        cycle(0, '0, "R10 hold");
        hart_rst = 4'b0000;
        cycle(1, mk(0,1,0,0,0,20'd1,0,1), "R10 overrides write");

        // R11: system reset follows bit 1
        cycle(1, mk(0,0,0,0,0,20'd2,1,1), "R11 set");
        cycle(1, mk(0,0,0,0,0,20'd2,0,1), "R11 clear");
        cycle(1, mk(0,0,0,0,0,20'd1,1,1), "R11 set again");

        // R3/R4: deactivate, fields in that write ignored; state cleared
        cycle(1, mk(1,0,0,1,0,20'd0,0,0), "R3 deactivate");
        cycle(0, '0, "R4 cleared");
        cycle(1, mk(1,0,0,1,0,20'd0,1,1), "R3 reactivate ignores fields");
        cycle(1, mk(1,0,0,0,0,20'd0,0,1), "R6 halt after reactivate");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule